// File: doc/BRIEF.md
# Preset and Self-Test Sequencer

This block is the controller-side state machine that brings an instrument through a reset and self-test cycle. Two events start a cycle. The first is an active-low preset request, raised at power-on or by the front-panel preset key. The second is the rising edge of a power-good line, which goes high once the supplies have settled. For as long as a cycle is being held, the block drives a fixed set of overrides. It overrides the shutdown logic, blocks RAM access, holds the main and display processors in reset, and lights every panel and self-test indicator.

Once the preset request has stayed released for a programmable debounce interval, the block runs seven test phases in a fixed order. Each phase uses a start/done/pass handshake with external test responders. A timeout counter limits how long each phase may take. If a phase fails, its index is recorded in a fail code and a sticky error flag is set, but the remaining phases still run.

The cycle ends with a single-cycle pulse. After a preset-key cycle this pulse asks for preset settings to be loaded. After a power-up cycle it asks for saved settings to be restored. The block then reports ready. If the preset request is asserted again at any point, the running sequence is abandoned and the block returns to the forced state.

Top module: `psq_top`

## Requirements
- R1: Within three clock edges of presetReqN going low, and for as long as it stays low, shutdownOverride, ramInhibit, cpuReset and dispReset are all 1, while ready and testStart are 0.
- R2: While the block is in the forced state, every bit of panelLeds and all 16 bits of selfTestLeds are 1. In every other state, all of these bits are 0.
- R3: After release, testStart pulses for exactly one cycle per phase. testPhase carries the phase index: 0 processor registers, 1 partial RAM, 2 ROM, 3 address bus, 4 data bus, 5 calibration checksum, 6 A/D converter. The indices appear in the order 0 to 6, and each start waits until the previous phase has completed.
- R4: A cycle that was not started by a power-good rise ends with exactly one loadPreset pulse, one cycle wide, and no restoreSaved pulse. On the cycle after that pulse, ready is 1.
- R5: A rising edge of powerGood forces the state of R1. The cycle it starts ends with exactly one single-cycle restoreSaved pulse and no loadPreset pulse.
- R6: A release is recognised only after the synchronised preset request has been high for DEBOUNCE_CYC consecutive cycles. A shorter high glitch starts no test phase and leaves the overrides asserted.
- R7: When a phase returns testDone with testPass = 0, errorFlag becomes 1 and failCode holds the index of the first phase that failed in the cycle. Both values persist through ready and are cleared only by a new forced state. The remaining phases still run, and the final pulse is still issued.
- R8: If testDone does not arrive within TIMEOUT_CYC cycles after a start, the phase counts as failed in the sense of R7, and the sequence moves on to the next phase.
- R9: If presetReqN goes low during the sequence, the block returns to the forced state and issues no final pulse. The next release restarts the sequence at phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; the block comes out of reset in the forced state |
| presetReqN | input | 1 | Active-low preset request, asynchronous |
| powerGood | input | 1 | High once supplies are stable; its rising edge starts a power-up cycle |
| testDone | input | 1 | Completion strobe from the test responder |
| testPass | input | 1 | Result of the phase, valid with testDone |
| testStart | output | 1 | Single-cycle start strobe for a phase |
| testPhase | output | 3 | Index of the current phase |
| shutdownOverride | output | 1 | Overrides the shutdown logic |
| ramInhibit | output | 1 | Blocks RAM access |
| cpuReset | output | 1 | Holds the main processor in reset |
| dispReset | output | 1 | Holds the display processor in reset |
| panelLeds | output | PANEL_W | Front-panel indicator drive |
| selfTestLeds | output | STLED_W | Self-test indicator drive (16 by default) |
| loadPreset | output | 1 | Pulse requesting that preset settings be loaded |
| restoreSaved | output | 1 | Pulse requesting that saved settings be restored |
| ready | output | 1 | The sequence has finished |
| errorFlag | output | 1 | Sticky flag: a phase failed in this cycle |
| failCode | output | 3 | Index of the first phase that failed |

## Verification
The bench sends a preset glitch shorter than the debounce interval. A design that sampled the raw release would start testing too early on that glitch. A failure is injected in two phases, to confirm that failCode keeps the first failing index and is not overwritten by the later one. The bench also withholds one done strobe, to show that a missing timeout would hang the sequence. Finally, it aborts the sequence in mid-run and then raises power-good. A design that leaked a final pulse after the abort, or that mixed up the two end actions, would show the wrong pulse count or the wrong pulse kind.

// File: rtl/psq_pkg.sv
package psq_pkg;
  localparam int unsigned NUM_PHASES = 7;
  localparam int unsigned PHASE_W = 3;

  typedef enum logic [2:0] {StHold, StStart, StWait, StFinish, StReady} seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCycle;
    logic clrTimer;
    logic incPhase;
    logic recordFail;
    logic finish;
  } seqCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic presetHeld;
    logic pgRise;
    logic dbDone;
    logic timeoutHit;
    logic lastPhase;
    logic pwrUpCycle;
  } seqStat_t;
endpackage

// File: rtl/psq_datapath.sv
module psq_datapath
  import psq_pkg::*;
#(
  parameter int unsigned DEBOUNCE_CYC = 8,
  parameter int unsigned TIMEOUT_CYC = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               presetReqN,
  input  logic               powerGood,
  input  seqCmd_t            cmd,
  output seqStat_t           stat,
  output logic [PHASE_W-1:0] phase,
  output logic               errorFlag,
  output logic [PHASE_W-1:0] failCode
);
  localparam int unsigned DW = $clog2(DEBOUNCE_CYC + 1);
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);

  logic [1:0] presetSync;
  logic [1:0] pgSync;
  logic pgPrev;
  logic [DW-1:0] dbCnt;
  logic [TW-1:0] timer;
  logic pwrUpFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presetSync <= 2'b00;
      pgSync <= 2'b00;
      pgPrev <= 1'b0;
    end else begin
      presetSync <= {presetSync[0], presetReqN};
      pgSync <= {pgSync[0], powerGood};
      pgPrev <= pgSync[1];
    end
  end

  assign stat.presetHeld = ~presetSync[1];
  assign stat.pgRise = pgSync[1] & ~pgPrev;

  // debounce: consecutive released cycles, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dbCnt <= '0;
    else if (stat.presetHeld || stat.pgRise) dbCnt <= '0;
    else if (dbCnt != DW'(DEBOUNCE_CYC)) dbCnt <= dbCnt + 1'b1;
  end
  assign stat.dbDone = (dbCnt == DW'(DEBOUNCE_CYC));

  // per-phase timeout
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timer <= '0;
    else if (cmd.clrTimer) timer <= '0;
    else if (timer != TW'(TIMEOUT_CYC - 1)) timer <= timer + 1'b1;
  end
  assign stat.timeoutHit = (timer == TW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else if (cmd.clrCycle) phase <= '0;
    else if (cmd.incPhase) phase <= phase + 1'b1;
  end
  assign stat.lastPhase = (phase == PHASE_W'(NUM_PHASES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errorFlag <= 1'b0;
      failCode <= '0;
    end else if (cmd.clrCycle) begin
      errorFlag <= 1'b0;
      failCode <= '0;
    end else if (cmd.recordFail && !errorFlag) begin
      errorFlag <= 1'b1;
      failCode <= phase;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwrUpFlag <= 1'b0;
    else if (stat.pgRise) pwrUpFlag <= 1'b1;
    else if (cmd.finish) pwrUpFlag <= 1'b0;
  end
  assign stat.pwrUpCycle = pwrUpFlag;

  // R8
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    timer <= TW'(TIMEOUT_CYC - 1));
  // R3
  phase_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    phase <= PHASE_W'(NUM_PHASES - 1));
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errorFlag && !cmd.clrCycle |=> errorFlag && $stable(failCode));
endmodule

// File: rtl/psq_ctrl.sv
module psq_ctrl
  import psq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  seqStat_t stat,
  input  logic     testDone,
  input  logic     testPass,
  output seqCmd_t  cmd,
  output logic     forced,
  output logic     testStart,
  output logic     loadPreset,
  output logic     restoreSaved,
  output logic     ready
);
  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= StHold;
    else state <= nextState;
  end

  always_comb begin
    nextState = state;
    cmd = '0;
    case (state)
      StHold: begin
        cmd.clrCycle = 1'b1;
        if (stat.dbDone) nextState = StStart;
      end
      StStart: begin
        cmd.clrTimer = 1'b1;
        nextState = StWait;
      end
      StWait: begin
        if (testDone || stat.timeoutHit) begin
          cmd.recordFail = testDone ? !testPass : 1'b1;
          if (stat.lastPhase) nextState = StFinish;
          else begin
            cmd.incPhase = 1'b1;
            nextState = StStart;
          end
        end
      end
      StFinish: begin
        cmd.finish = 1'b1;
        nextState = StReady;
      end
      default: nextState = StReady;
    endcase
    if (stat.presetHeld || stat.pgRise) nextState = StHold;
  end

  assign forced = (state == StHold);
  assign testStart = (state == StStart);
  assign loadPreset = (state == StFinish) && !stat.pwrUpCycle;
  assign restoreSaved = (state == StFinish) && stat.pwrUpCycle;
  assign ready = (state == StReady);

  // R1
  hold_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    stat.presetHeld |=> forced && !testStart && !ready);
  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    testStart |=> !testStart);
  // R4
  load_then_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadPreset && !stat.presetHeld && !stat.pgRise |=> ready);
  // R5
  end_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(loadPreset && restoreSaved));
endmodule

// File: rtl/psq_top.sv
module psq_top
  import psq_pkg::*;
#(
  parameter int unsigned DEBOUNCE_CYC = 8,
  parameter int unsigned TIMEOUT_CYC = 64,
  parameter int unsigned PANEL_W = 8,
  parameter int unsigned STLED_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               presetReqN,
  input  logic               powerGood,
  input  logic               testDone,
  input  logic               testPass,
  output logic               testStart,
  output logic [2:0]         testPhase,
  output logic               shutdownOverride,
  output logic               ramInhibit,
  output logic               cpuReset,
  output logic               dispReset,
  output logic [PANEL_W-1:0] panelLeds,
  output logic [STLED_W-1:0] selfTestLeds,
  output logic               loadPreset,
  output logic               restoreSaved,
  output logic               ready,
  output logic               errorFlag,
  output logic [2:0]         failCode
);
  seqCmd_t cmd;
  seqStat_t stat;
  logic forced;

  psq_datapath #(.DEBOUNCE_CYC(DEBOUNCE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) dp (
    .clk(clk), .rstN(rstN), .presetReqN(presetReqN), .powerGood(powerGood),
    .cmd(cmd), .stat(stat), .phase(testPhase), .errorFlag(errorFlag),
    .failCode(failCode)
  );

  psq_ctrl ctl (
    .clk(clk), .rstN(rstN), .stat(stat), .testDone(testDone), .testPass(testPass),
    .cmd(cmd), .forced(forced), .testStart(testStart), .loadPreset(loadPreset),
    .restoreSaved(restoreSaved), .ready(ready)
  );

  assign shutdownOverride = forced;
  assign ramInhibit = forced;
  assign cpuReset = forced;
  assign dispReset = forced;
  assign panelLeds = {PANEL_W{forced}};
  assign selfTestLeds = {STLED_W{forced}};
endmodule

// File: tb/psq_top_test.sv
module psq_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEB = 8;
  localparam int TMO = 20;

  logic clk = 0, rstN = 0, presetReqN = 0, powerGood = 0, testDone = 0, testPass = 0;
  logic testStart, shutdownOverride, ramInhibit, cpuReset, dispReset;
  logic loadPreset, restoreSaved, ready, errorFlag;
  logic [2:0] testPhase, failCode;
  logic [7:0] panelLeds;
  logic [15:0] selfTestLeds;

  int checks = 0, fails = 0;
  int starts = 0, loads = 0, restores = 0, pend = 0, lat = 3;
  logic [6:0] failMask = 0, skipMask = 0;
  int order [8];
  logic curPass = 1;

  psq_top #(.DEBOUNCE_CYC(DEB), .TIMEOUT_CYC(TMO)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // responder and monitor, away from the active edge
  always @(negedge clk) begin
    testDone <= 0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin testDone <= 1; testPass <= curPass; end
    end
    if (loadPreset) loads++;
    if (restoreSaved) restores++;
    if (testStart) begin
      if (starts < 8) order[starts] = int'(testPhase);
      starts++;
      if (!skipMask[testPhase]) begin
        pend = lat;
        curPass = !failMask[testPhase];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clrLog();
    starts = 0; loads = 0; restores = 0;
    for (int i = 0; i < 8; i++) order[i] = -1;
  endtask

  task automatic waitReady();
    for (int i = 0; i < 2000 && !ready; i++) @(negedge clk);
  endtask

  task automatic checkForced(input string tag);
    chk({shutdownOverride, ramInhibit, cpuReset, dispReset} == 4'hF, {tag, " R1 overrides"},
        {shutdownOverride, ramInhibit, cpuReset, dispReset}, 15);
    chk(!ready && !testStart, {tag, " R1 ready/start low"}, {ready, testStart}, 0);
    chk(panelLeds == 8'hFF && selfTestLeds == 16'hFFFF, {tag, " R2 indicators on"},
        int'(selfTestLeds), 16'hFFFF);
  endtask

  task automatic checkOrder(input string tag);
    bit ok = (starts == 7);
    for (int i = 0; i < 7; i++) if (order[i] != i) ok = 0;
    chk(ok, {tag, " R3 phase order"}, starts, 7);
  endtask

  task automatic keyCycle();
    presetReqN = 0;
    repeat (6) @(negedge clk);
    clrLog();
    presetReqN = 1;
    waitReady();
    @(negedge clk);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (5) @(negedge clk);
    checkForced("reset");
  endtask

  task automatic testDebounce();
    clrLog();
    presetReqN = 1;
    repeat (DEB - 4) @(negedge clk);
    presetReqN = 0;
    repeat (DEB + 6) @(negedge clk);
    chk(starts == 0, "R6 glitch started no phase", starts, 0);
    checkForced("R6 glitch");
  endtask

  task automatic testClean();
    keyCycle();
    checkOrder("clean");
    chk(loads == 1 && restores == 0, "R4 one load pulse", loads, 1);
    chk(ready, "R4 ready after load", ready, 1);
    chk(panelLeds == 0 && selfTestLeds == 0 && !shutdownOverride, "R2 indicators off when ready",
        int'(selfTestLeds), 0);
    chk(!errorFlag, "R7 no error on clean run", errorFlag, 0);
  endtask

  task automatic testFail();
    failMask = 7'b0101000;
    keyCycle();
    checkOrder("R7 fail run");
    chk(errorFlag && failCode == 3, "R7 first fail code", failCode, 3);
    chk(loads == 1, "R7 final pulse still issued", loads, 1);
    failMask = 0;
    presetReqN = 0;
    repeat (5) @(negedge clk);
    chk(!errorFlag && failCode == 0, "R7 cleared by hold", errorFlag, 0);
  endtask

  task automatic testTimeout();
    skipMask = 7'b0000100;
    keyCycle();
    checkOrder("R8 timeout run");
    chk(errorFlag && failCode == 2, "R8 timeout fail code", failCode, 2);
    chk(ready && loads == 1, "R8 sequence completed", loads, 1);
    skipMask = 0;
  endtask

  task automatic testAbort();
    presetReqN = 0;
    repeat (6) @(negedge clk);
    clrLog();
    presetReqN = 1;
    for (int i = 0; i < 500 && starts < 3; i++) @(negedge clk);
    presetReqN = 0;
    repeat (4) @(negedge clk);
    checkForced("R9 abort");
    repeat (20) @(negedge clk);
    chk(loads == 0 && restores == 0, "R9 no pulse after abort", loads, 0);
    clrLog();
    presetReqN = 1;
    waitReady();
    @(negedge clk);
    checkOrder("R9 restart");
    chk(loads == 1, "R9 restart load", loads, 1);
  endtask

  task automatic testPowerGood();
    clrLog();
    powerGood = 1;
    repeat (4) @(negedge clk);
    checkForced("R5 power-good");
    waitReady();
    @(negedge clk);
    checkOrder("R5 power-up");
    chk(restores == 1 && loads == 0, "R5 restore pulse only", restores, 1);
    keyCycle();
    chk(loads == 1 && restores == 0, "R4 key cycle after power-up", loads, 1);
  endtask

  initial begin
    clrLog();
    testReset();
    testDebounce();
    testClean();
    testFail();
    testTimeout();
    testAbort();
    testPowerGood();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule